// File: doc/BRIEF.md
# MSI Event Queue Controller

This block takes posted message-signalled-interrupt writes, already decoded from the inbound PCIe path into an address offset and a 32-bit data word, and turns them into entries in circular event queues held in system memory. The address offset selects one of up to `NUM_Q` queues. Each accepted message is written unchanged to the next free slot of its queue through a simple memory write-request port. The queue's tail pointer is owned by the hardware and moves on only after the memory side acknowledges the write.

Software drains a queue by reading the entries from its head up to, but not including, the tail. It then writes the new head value back. Each queue drives its own level interrupt line, which stays high while the queue holds unconsumed entries and its enables are set. If a message arrives while its queue is full, the message is dropped and a sticky overflow flag is raised for that queue. Software clears the flag by writing 1 to it.

Two layouts are supported, chosen at build time. In shared-region mode, all queues lie back to back in one 4 KB page. In per-region mode, each queue has its own 4 KB page and the queue is selected by a 4 KB address stride.

Top module: `msi_evq_ctrl`

## Requirements
- R1: After reset, every register reads zero, all interrupt lines are low and `msi_ready` is high.
- R2: In shared-region mode, a message at byte offset 4·n selects queue n. A message whose offset has nonzero bits [1:0], or whose word index is at least `NUM_Q`, is ignored: it produces no memory write and no pointer change.
- R3: An accepted message to queue n with tail t is written with its data unchanged. In shared-region mode the write address is page(0) + n·256 + 4·t.
- R4: `mem_req` stays high, with address and data held, until `mem_ack`. The tail advances only on the acknowledged cycle, and `msi_ready` is low while a write is outstanding.
- R5: The 6-bit tail wraps from 63 to 0. Software writes to the tail register are ignored.
- R6: When tail+1 equals head (modulo 64), a message to that queue is dropped and bit n of the overflow register (global word 1) is set. Writing 1 to that bit clears it.
- R7: A message to a queue whose control bit 0 (queue enable) is clear is dropped, with no memory write and no overflow.
- R8: `irq_out[n]` is high exactly when control bits 0, 1 and 11 are all set, the mask bit n is set, and head differs from tail. Writing head equal to tail drops the line.
- R9: The mask register (global word 0) has bit n for queue n. A clear bit holds that queue's line low.
- R10: In per-region mode, queue n is selected by offset bits [15:12]. Offset bits [11:2] are ignored, and the write address is page(n) + 4·t.
- R11: Register address bits [7:4] select a queue, or 15 for the global block. Bits [3:2] select control (0), head (1), tail (2) or page base (3). The page base register reads back with bits [11:0] as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msi_valid | input | 1 | Message write present |
| msi_addr | input | MSI_AW | Byte offset of the message within the interrupt window |
| msi_data | input | DATA_W | Message data |
| msi_ready | output | 1 | Block can take a message this cycle |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory write byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory write done |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| irq_out | output | NUM_Q | Per-queue level interrupt |

## Verification
Every queue receives messages in turn while the memory latency rotates through 0 to 2 cycles. This separates a queue-offset error from a tail-offset error in the write address. One queue is then filled to 63 entries and given one more message, which tells a correct full test apart from an off-by-one that either drops one entry too early or overwrites the oldest entry. Moving the head past the wrap point separates modulo pointer arithmetic from saturating arithmetic. A long-latency write, with the tail read while the write is still pending, shows whether the pointer moves before the acknowledge. Each enable is then cleared on its own, and messages are sent to misaligned and out-of-range offsets, to confirm that each gate acts alone. A second instance in per-region mode checks the 4 KB stride selection and per-queue page use.

// File: rtl/msi_evq_pkg.sv
// Shared definitions for the event queue controller: control bit
// positions, register select codes and the write sequencer states.
package msi_evq_pkg;
    localparam int CTRL_QEN_BIT = 0;
    localparam int CTRL_EVT_BIT = 1;
    localparam int CTRL_IEN_BIT = 11;

    typedef enum logic [1:0] {
        QREG_CTRL = 2'd0,
        QREG_HEAD = 2'd1,
        QREG_TAIL = 2'd2,
        QREG_PAGE = 2'd3
    } qreg_sel_e;

    typedef enum logic [1:0] {
        GREG_MASK = 2'd0,
        GREG_OVF  = 2'd1
    } greg_sel_e;

    typedef enum logic {
        WR_IDLE = 1'b0,
        WR_BUSY = 1'b1
    } wr_state_e;
endpackage

// File: rtl/msi_evq_decode.sv
// Maps a message byte offset to a queue index.
// Assumes: offsets are relative to the interrupt window base; the layout
// mode is fixed at build time.
module msi_evq_decode #(
    parameter int NUM_Q      = 6,
    parameter int QW         = 3,
    parameter int MSI_AW     = 16,
    parameter int PAGE_LSB   = 12,
    parameter bit PER_REGION = 1'b0
) (
    input  logic [MSI_AW-1:0] msi_addr,
    output logic              hit,
    output logic [QW-1:0]     q_idx
);
    logic [MSI_AW-1:0] group;
    logic              unused_addr_bits;

    assign unused_addr_bits = ^msi_addr;

    generate
        if (PER_REGION) begin : g_region
            // one 4 KB page per queue: group is the page number
            always_comb group = MSI_AW'(msi_addr >> PAGE_LSB);
        end else begin : g_shared
            // one shared page: group is the word index
            always_comb group = MSI_AW'(msi_addr >> 2);
        end
    endgenerate

    // accept only word-aligned offsets naming an existing queue
    always_comb begin
        hit   = (msi_addr[1:0] == 2'b00) && (group < MSI_AW'(NUM_Q));
        q_idx = group[QW-1:0];
    end
endmodule

// File: rtl/msi_evq_queue.sv
// State of one event queue: control bits, software head, hardware tail,
// page base and sticky overflow flag; derives full and the interrupt.
// Assumes: push and ovf_set are never raised in the same cycle.
module msi_evq_queue
    import msi_evq_pkg::*;
#(
    parameter int PTR_W    = 6,
    parameter int ADDR_W   = 32,
    parameter int PAGE_LSB = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [2:0]        ctrl_bits,
    input  logic              head_we,
    input  logic [PTR_W-1:0]  head_in,
    input  logic              page_we,
    input  logic [ADDR_W-PAGE_LSB-1:0] page_in,
    input  logic              mask_ok,
    input  logic              push,
    input  logic              ovf_set,
    input  logic              ovf_clr,
    output logic              q_en,
    output logic              evt_en,
    output logic              int_en,
    output logic [PTR_W-1:0]  head,
    output logic [PTR_W-1:0]  tail,
    output logic [ADDR_W-1:0] page,
    output logic              ovf,
    output logic              full,
    output logic              irq
);
    logic [ADDR_W-PAGE_LSB-1:0] page_hi;
    logic [PTR_W-1:0]           tail_nx;

    // control enables, written whole by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_en   <= 1'b0;
            evt_en <= 1'b0;
            int_en <= 1'b0;
        end else if (ctrl_we) begin
            q_en   <= ctrl_bits[0];
            evt_en <= ctrl_bits[1];
            int_en <= ctrl_bits[2];
        end
    end

    // head pointer: software owned
    always_ff @(posedge clk) begin
        if (!rst_n)       head <= '0;
        else if (head_we) head <= head_in;
    end

    // tail pointer: moves only on an acknowledged entry write
    always_ff @(posedge clk) begin
        if (!rst_n)    tail <= '0;
        else if (push) tail <= tail_nx;
    end

    // page base, 4 KB aligned
    always_ff @(posedge clk) begin
        if (!rst_n)       page_hi <= '0;
        else if (page_we) page_hi <= page_in;
    end

    // sticky overflow, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf <= 1'b0;
        else if (ovf_set) ovf <= 1'b1;
        else if (ovf_clr) ovf <= 1'b0;
    end

    // derived status and interrupt level
    always_comb begin
        tail_nx = tail + 1'b1;
        full    = (tail_nx == head);
        page    = {page_hi, {PAGE_LSB{1'b0}}};
        irq     = q_en && evt_en && int_en && mask_ok && (head != tail);
    end
endmodule

// File: rtl/msi_evq_writer.sv
// Accepts one message at a time, checks its queue, and issues the entry
// write to memory; pulses push on acknowledge or ovf_set on a full drop.
// Assumes: the memory side holds mem_ack high for one cycle per write.
module msi_evq_writer
    import msi_evq_pkg::*;
#(
    parameter int NUM_Q      = 6,
    parameter int QW         = 3,
    parameter int PTR_W      = 6,
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int MSI_AW     = 16,
    parameter int PAGE_LSB   = 12,
    parameter bit PER_REGION = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    msi_valid,
    input  logic [MSI_AW-1:0]       msi_addr,
    input  logic [DATA_W-1:0]       msi_data,
    output logic                    msi_ready,
    input  logic [NUM_Q-1:0]        q_en_vec,
    input  logic [NUM_Q-1:0]        full_vec,
    input  logic [NUM_Q*PTR_W-1:0]  tail_flat,
    input  logic [NUM_Q*ADDR_W-1:0] page_flat,
    output logic                    mem_req,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    input  logic                    mem_ack,
    output logic [NUM_Q-1:0]        push_vec,
    output logic [NUM_Q-1:0]        ovf_set_vec
);
    localparam int Q_BYTES = (1 << PTR_W) * 4;

    wr_state_e         state;
    logic              hit;
    logic [QW-1:0]     sel_q;
    logic [QW-1:0]     cur_q;
    logic [PTR_W-1:0]  sel_tail;
    logic [ADDR_W-1:0] sel_base;
    logic [ADDR_W-1:0] entry_addr;
    logic              accept;
    logic              take;
    logic              drop_full;
    logic              unused_page_bits;

    assign unused_page_bits = ^page_flat;

    msi_evq_decode #(
        .NUM_Q(NUM_Q), .QW(QW), .MSI_AW(MSI_AW),
        .PAGE_LSB(PAGE_LSB), .PER_REGION(PER_REGION)
    ) u_decode (
        .msi_addr(msi_addr),
        .hit     (hit),
        .q_idx   (sel_q)
    );

    generate
        if (PER_REGION) begin : g_base_region
            // each queue starts at its own page
            always_comb sel_base = page_flat[sel_q*ADDR_W +: ADDR_W];
        end else begin : g_base_shared
            // queues packed behind page 0
            always_comb sel_base = page_flat[ADDR_W-1:0]
                                 + ADDR_W'(sel_q) * ADDR_W'(Q_BYTES);
        end
    endgenerate

    // entry address and accept/drop decision for the offered message
    always_comb begin
        sel_tail   = tail_flat[sel_q*PTR_W +: PTR_W];
        entry_addr = sel_base + ADDR_W'({sel_tail, 2'b00});
        accept     = (state == WR_IDLE) && msi_valid;
        take       = accept && hit && q_en_vec[sel_q] && !full_vec[sel_q];
        drop_full  = accept && hit && q_en_vec[sel_q] && full_vec[sel_q];
    end

    // one-hot strobes towards the queue state
    always_comb begin
        push_vec    = '0;
        ovf_set_vec = '0;
        if (state == WR_BUSY && mem_ack) push_vec[cur_q] = 1'b1;
        if (drop_full)                   ovf_set_vec[sel_q] = 1'b1;
    end

    // sequencer: idle until a message is taken, busy until acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WR_IDLE;
        end else if (state == WR_IDLE) begin
            if (take) state <= WR_BUSY;
        end else if (mem_ack) begin
            state <= WR_IDLE;
        end
    end

    // hold the request fields for the whole write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q     <= '0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else if (take) begin
            cur_q     <= sel_q;
            mem_addr  <= entry_addr;
            mem_wdata <= msi_data;
        end
    end

    assign mem_req   = (state == WR_BUSY);
    assign msi_ready = (state == WR_IDLE);
endmodule

// File: rtl/msi_evq_ctrl.sv
// Top of the event queue controller: per-queue state, register access,
// optional interrupt mask and the memory write sequencer.
// Assumes: NUM_Q <= 15 (register block 15 is global); ADDR_W <= 32.
module msi_evq_ctrl
    import msi_evq_pkg::*;
#(
    parameter int NUM_Q      = 6,
    parameter int PTR_W      = 6,
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int MSI_AW     = 16,
    parameter bit PER_REGION = 1'b0,
    parameter bit HAS_MASK   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msi_valid,
    input  logic [MSI_AW-1:0] msi_addr,
    input  logic [DATA_W-1:0] msi_data,
    output logic              msi_ready,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [NUM_Q-1:0]  irq_out
);
    localparam int       QW       = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;
    localparam int       REG_W    = 32;
    localparam int       PAGE_LSB = 12;
    localparam bit [3:0] GLB_BLK  = 4'hF;

    logic [3:0]              blk;
    logic [1:0]              word;
    logic                    glb_wr;
    logic [NUM_Q-1:0]        q_en_vec, evt_vec, ien_vec;
    logic [NUM_Q-1:0]        full_vec, ovf_vec, mask_ok;
    logic [NUM_Q-1:0]        push_vec, ovf_set_vec;
    logic [PTR_W-1:0]        head_arr [NUM_Q];
    logic [PTR_W-1:0]        tail_arr [NUM_Q];
    logic [ADDR_W-1:0]       page_arr [NUM_Q];
    logic [NUM_Q*PTR_W-1:0]  head_flat, tail_flat;
    logic [NUM_Q*ADDR_W-1:0] page_flat;
    logic [NUM_Q-1:0]        mask_rd;
    logic                    unused_wdata_bits;

    assign unused_wdata_bits = ^reg_wdata;
    assign blk    = reg_addr[7:4];
    assign word   = reg_addr[3:2];
    assign glb_wr = reg_wr && (blk == GLB_BLK);

    generate
        if (HAS_MASK) begin : g_mask
            logic [NUM_Q-1:0] mask_q;
            // per-queue interrupt mask, set by software
            always_ff @(posedge clk) begin
                if (!rst_n) mask_q <= '0;
                else if (glb_wr && word == GREG_MASK) mask_q <= reg_wdata[NUM_Q-1:0];
            end
            assign mask_ok = mask_q;
            assign mask_rd = mask_q;
        end else begin : g_nomask
            assign mask_ok = '1;
            assign mask_rd = '0;
        end

        for (genvar gi = 0; gi < NUM_Q; gi++) begin : g_q
            logic sel;
            assign sel = reg_wr && (blk == 4'(gi));

            msi_evq_queue #(
                .PTR_W(PTR_W), .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB)
            ) u_queue (
                .clk      (clk),
                .rst_n    (rst_n),
                .ctrl_we  (sel && word == QREG_CTRL),
                .ctrl_bits({reg_wdata[CTRL_IEN_BIT], reg_wdata[CTRL_EVT_BIT],
                            reg_wdata[CTRL_QEN_BIT]}),
                .head_we  (sel && word == QREG_HEAD),
                .head_in  (reg_wdata[PTR_W-1:0]),
                .page_we  (sel && word == QREG_PAGE),
                .page_in  (reg_wdata[ADDR_W-1:PAGE_LSB]),
                .mask_ok  (mask_ok[gi]),
                .push     (push_vec[gi]),
                .ovf_set  (ovf_set_vec[gi]),
                .ovf_clr  (glb_wr && word == GREG_OVF && reg_wdata[gi]),
                .q_en     (q_en_vec[gi]),
                .evt_en   (evt_vec[gi]),
                .int_en   (ien_vec[gi]),
                .head     (head_arr[gi]),
                .tail     (tail_arr[gi]),
                .page     (page_arr[gi]),
                .ovf      (ovf_vec[gi]),
                .full     (full_vec[gi]),
                .irq      (irq_out[gi])
            );

            assign head_flat[gi*PTR_W +: PTR_W]   = head_arr[gi];
            assign tail_flat[gi*PTR_W +: PTR_W]   = tail_arr[gi];
            assign page_flat[gi*ADDR_W +: ADDR_W] = page_arr[gi];
        end
    endgenerate

    msi_evq_writer #(
        .NUM_Q(NUM_Q), .QW(QW), .PTR_W(PTR_W), .ADDR_W(ADDR_W),
        .DATA_W(DATA_W), .MSI_AW(MSI_AW), .PAGE_LSB(PAGE_LSB),
        .PER_REGION(PER_REGION)
    ) u_writer (
        .clk        (clk),
        .rst_n      (rst_n),
        .msi_valid  (msi_valid),
        .msi_addr   (msi_addr),
        .msi_data   (msi_data),
        .msi_ready  (msi_ready),
        .q_en_vec   (q_en_vec),
        .full_vec   (full_vec),
        .tail_flat  (tail_flat),
        .page_flat  (page_flat),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .push_vec   (push_vec),
        .ovf_set_vec(ovf_set_vec)
    );

    // register read mux, unmapped locations return zero
    always_comb begin
        reg_rdata = '0;
        if (blk == GLB_BLK) begin
            case (word)
                GREG_MASK: reg_rdata[NUM_Q-1:0] = mask_rd;
                GREG_OVF:  reg_rdata[NUM_Q-1:0] = ovf_vec;
                default:   reg_rdata = '0;
            endcase
        end else if (blk < 4'(NUM_Q)) begin
            case (word)
                QREG_CTRL: begin
                    reg_rdata[CTRL_QEN_BIT] = q_en_vec[blk[QW-1:0]];
                    reg_rdata[CTRL_EVT_BIT] = evt_vec[blk[QW-1:0]];
                    reg_rdata[CTRL_IEN_BIT] = ien_vec[blk[QW-1:0]];
                end
                QREG_HEAD: reg_rdata = REG_W'(head_arr[blk[QW-1:0]]);
                QREG_TAIL: reg_rdata = REG_W'(tail_arr[blk[QW-1:0]]);
                default:   reg_rdata = REG_W'(page_arr[blk[QW-1:0]]);
            endcase
        end
    end
endmodule

// File: rtl/msi_evq_checker.sv
// Temporal checks on the event queue controller, bound to every instance.
module msi_evq_checker #(
    parameter int NUM_Q  = 6,
    parameter int PTR_W  = 6,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   msi_ready,
    input logic                   mem_req,
    input logic                   mem_ack,
    input logic [ADDR_W-1:0]      mem_addr,
    input logic [DATA_W-1:0]      mem_wdata,
    input logic [NUM_Q-1:0]       irq_out,
    input logic [NUM_Q*PTR_W-1:0] head_flat,
    input logic [NUM_Q*PTR_W-1:0] tail_flat
);
    logic [NUM_Q-1:0] pend;

    // queues holding unconsumed entries
    always_comb begin
        for (int i = 0; i < NUM_Q; i++)
            pend[i] = head_flat[i*PTR_W +: PTR_W] != tail_flat[i*PTR_W +: PTR_W];
    end

    assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

    assert_busy_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !msi_ready);

    assert_tail_on_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tail_flat) |-> $past(mem_req && mem_ack));

    assert_irq_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & ~pend) == '0);

    assert_word_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));
endmodule

bind msi_evq_ctrl msi_evq_checker #(
    .NUM_Q(NUM_Q), .PTR_W(PTR_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .msi_ready(msi_ready),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .irq_out  (irq_out),
    .head_flat(head_flat),
    .tail_flat(tail_flat)
);

// File: tb/msi_evq_ctrl_bench.sv
// Bench: shared-region instance swept over all queues, plus a per-region instance.
module msi_evq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] msi_addr = '0;
    logic [31:0] msi_data = '0;
    logic        a_valid = 1'b0, b_valid = 1'b0;
    logic        a_ready, b_ready;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        a_wr = 1'b0, b_wr = 1'b0;
    logic [31:0] a_rdata, b_rdata;
    logic        a_req, b_req;
    logic        a_ack = 1'b0;
    logic        b_ack;
    logic [31:0] a_maddr, a_mdata, b_maddr, b_mdata;
    logic [5:0]  a_irq, b_irq;

    int checks = 0, errors = 0;
    int lat_a = 0, a_wait = 0, a_cnt = 0, b_cnt = 0;
    logic [31:0] a_last_addr = '0, a_last_data = '0, b_last_addr = '0;

    always #2.5 clk = ~clk;

    msi_evq_ctrl u_msi_evq_ctrl (
        .clk(clk), .rst_n(rst_n), .msi_valid(a_valid), .msi_addr(msi_addr),
        .msi_data(msi_data), .msi_ready(a_ready), .mem_req(a_req),
        .mem_addr(a_maddr), .mem_wdata(a_mdata), .mem_ack(a_ack),
        .reg_wr(a_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(a_rdata), .irq_out(a_irq));

    msi_evq_ctrl #(.PER_REGION(1'b1)) u_msi_evq_ctrl_region (
        .clk(clk), .rst_n(rst_n), .msi_valid(b_valid), .msi_addr(msi_addr),
        .msi_data(msi_data), .msi_ready(b_ready), .mem_req(b_req),
        .mem_addr(b_maddr), .mem_wdata(b_mdata), .mem_ack(b_ack),
        .reg_wr(b_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(b_rdata), .irq_out(b_irq));

    assign b_ack = b_req;

    // memory model for the shared instance with adjustable latency
    always @(negedge clk) begin
        if (a_req && !a_ack) begin
            if (a_wait >= lat_a) begin
                a_ack = 1'b1; a_wait = 0; a_cnt++;
                a_last_addr = a_maddr; a_last_data = a_mdata;
            end else a_wait++;
        end else a_ack = 1'b0;
    end

    // write log for the per-region instance
    always @(negedge clk) if (b_req) begin b_cnt++; b_last_addr = b_maddr; end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input bit sel_b, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d;
        if (sel_b) b_wr = 1'b1; else a_wr = 1'b1;
        @(negedge clk); a_wr = 1'b0; b_wr = 1'b0;
    endtask

    task automatic reg_expect(input bit sel_b, input logic [7:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a; #1;
        chk(tag, sel_b ? b_rdata : a_rdata, exp);
    endtask

    task automatic msi_send(input bit sel_b, input logic [15:0] a, input logic [31:0] d);
        @(negedge clk); msi_addr = a; msi_data = d;
        if (sel_b) b_valid = 1'b1; else a_valid = 1'b1;
        @(negedge clk); a_valid = 1'b0; b_valid = 1'b0;
        while (!(sel_b ? b_ready : a_ready)) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        reg_expect(0, 8'h00, 0, "R1 ctrl q0");
        reg_expect(0, 8'h54, 0, "R1 head q5");
        reg_expect(0, 8'h28, 0, "R1 tail q2");
        reg_expect(0, 8'h0C, 0, "R1 page q0");
        reg_expect(0, 8'hF0, 0, "R1 mask");
        reg_expect(0, 8'hF4, 0, "R1 overflow");
        chk("R1 irq", 32'(a_irq), 0);
        chk("R1 ready", 32'(a_ready), 1);

        // R7: disabled queue drops the message
        n0 = a_cnt;
        msi_send(0, 16'h0000, 32'h1234);
        chk("R7 no write", a_cnt, n0);
        reg_expect(0, 8'h08, 0, "R7 tail");
        reg_expect(0, 8'hF4, 0, "R7 no overflow");

        // R11: page register keeps only the 4 KB aligned part
        reg_write(0, 8'h0C, 32'h8000_0ABC);
        reg_expect(0, 8'h0C, 32'h8000_0000, "R11 page low bits");
        for (int q = 0; q < 6; q++) reg_write(0, 8'(q*16), 32'h803);
        reg_write(0, 8'hF0, 32'h3F);
        reg_expect(0, 8'h20, 32'h803, "R11 ctrl readback");

        // R2/R3: sweep every queue, rotating memory latency
        for (int k = 0; k < 3; k++)
            for (int q = 0; q < 6; q++) begin
                lat_a = (q + k) % 3;
                n0 = a_cnt;
                msi_send(0, 16'(q*4), 32'hA000 + 32'(q*16 + k));
                chk("R2 write issued", a_cnt, n0 + 1);
                chk("R3 address", a_last_addr, 32'h8000_0000 + 32'(q*256 + k*4));
                chk("R3 data", a_last_data, 32'hA000 + 32'(q*16 + k));
            end
        for (int q = 0; q < 6; q++) reg_expect(0, 8'(q*16 + 8), 3, "R3 tail count");
        chk("R8 all pending", 32'(a_irq), 32'h3F);

        // R6: fill queue 2 to 63 entries, then overflow
        lat_a = 0;
        for (int k = 3; k < 63; k++) msi_send(0, 16'h0008, 32'(k));
        reg_expect(0, 8'h28, 63, "R6 tail at 63");
        chk("R3 last slot", a_last_addr, 32'h8000_0000 + 32'(512 + 62*4));
        n0 = a_cnt;
        msi_send(0, 16'h0008, 32'hDEAD);
        chk("R6 full drop", a_cnt, n0);
        reg_expect(0, 8'h28, 63, "R6 tail unchanged");
        reg_expect(0, 8'hF4, 32'h4, "R6 overflow set");
        reg_write(0, 8'hF4, 32'h4);
        reg_expect(0, 8'hF4, 0, "R6 overflow cleared");

        // R8/R5: head catches up, then wrap
        reg_write(0, 8'h24, 63);
        chk("R8 head equals tail", 32'(a_irq[2]), 0);
        msi_send(0, 16'h0008, 32'hCAFE);
        chk("R5 wrap address", a_last_addr, 32'h8000_0000 + 32'(512 + 63*4));
        reg_expect(0, 8'h28, 0, "R5 tail wrapped");
        chk("R8 pending again", 32'(a_irq[2]), 1);
        reg_write(0, 8'h08, 9);
        reg_expect(0, 8'h08, 3, "R5 tail read only");

        // R9/R8: each gate alone
        reg_write(0, 8'hF0, 32'h3E);
        reg_write(0, 8'h10, 32'h003);
        reg_write(0, 8'h30, 32'h801);
        chk("R9 R8 gates", 32'(a_irq), 32'h34);
        reg_write(0, 8'h40, 0);
        chk("R7 line off", 32'(a_irq), 32'h24);
        n0 = a_cnt;
        msi_send(0, 16'h0010, 32'h1);
        chk("R7 disabled q4", a_cnt, n0);
        reg_expect(0, 8'h48, 3, "R7 tail q4");

        // R2: misaligned and out-of-range offsets
        msi_send(0, 16'h0018, 32'h2);
        msi_send(0, 16'h0005, 32'h3);
        msi_send(0, 16'h1000, 32'h4);
        chk("R2 ignored offsets", a_cnt, n0);

        // R4: tail held while write outstanding
        lat_a = 6;
        fork
            msi_send(0, 16'h0014, 32'hBEEF);
            begin
                repeat (3) @(negedge clk);
                chk("R4 req held", 32'(a_req), 1);
                chk("R4 not ready", 32'(a_ready), 0);
                reg_expect(0, 8'h58, 3, "R4 tail before ack");
            end
        join
        reg_expect(0, 8'h58, 4, "R4 tail after ack");
        chk("R4 address", a_last_addr, 32'h8000_0000 + 32'(5*256 + 12));

        // R10: per-region instance
        reg_write(1, 8'h1C, 32'h4000_3ABC);
        reg_write(1, 8'h10, 32'h803);
        msi_send(1, 16'h1000, 32'h55);
        chk("R10 page 1 slot 0", b_last_addr, 32'h4000_3000);
        msi_send(1, 16'h1008, 32'h56);
        chk("R10 offset bits ignored", b_last_addr, 32'h4000_3004);
        reg_expect(1, 8'h18, 2, "R10 tail q1");
        chk("R10 write count", b_cnt, 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule